// File: doc/BRIEF.md
# BCD Calendar Clock with Frozen Read Snapshot

This block is a time-of-day and calendar core. It counts seconds, minutes, hours, a weekday, day of month, month, two-digit year and century, all as packed BCD bytes. It advances on a single-cycle one-second tick input. The counters run all the time. A second bank of visible registers copies them on every cycle, and the register bus reads only from that visible bank.

To read a consistent snapshot, software sets a hold flag in the century register. While the flag is set, the visible bank keeps the values it had when the flag was set, but the counters keep running. When software clears the flag, every visible register reloads from the counters on the same edge. That reload comes well before the next second tick. The starting date and time after reset come from a parameter; there is no path for writing the time.

Top module: `bcd_cal_clock`

## Requirements
- R1: After reset the visible registers read seconds 00, minutes 00, hours 00, weekday 01, date 01, month 01, year 00, century 20 (BCD), with the hold flag clear; these are the default values of the start-time parameter.
- R2: A read returns, combinationally, the visible byte chosen by the address: 0 seconds, 1 minutes, 2 hours (24-hour), 3 weekday, 4 date, 5 month, 6 year, 7 century. Every field is packed BCD with the tens digit in bits 7:4.
- R3: Each tick advances the seconds. Seconds wrap 59 to 00 and carry into the minutes. Minutes wrap 59 to 00 and carry into the hours. Hours wrap 23 to 00.
- R4: The weekday steps only when the time rolls from 23:59:59 to 00:00:00. It goes 1 through 7 and then wraps back to 1.
- R5: The date wraps to 01 after day 31 in January, March, May, July, August, October and December, and after day 30 in April, June, September and November. In February it wraps after day 29 when the two-digit year is divisible by four, including year 00, and after day 28 otherwise.
- R6: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00 and carries into the century. The century counts 00 through 39 and then wraps to 00.
- R7: A bus write to address 7 sets the hold flag to the value of write-data bit 6. While the flag is set, the visible registers keep the values they had on the edge that set it.
- R8: While the hold flag is set, the internal counters keep advancing. The first clock edge after the flag clears loads every visible register from the counters at once, so no ticks are lost.
- R9: Bus writes have no effect on any time or date value. A write to an address other than 7 also leaves the hold flag unchanged.
- R10: A read of address 7 returns the BCD century in bits 5:0, the hold flag in bit 6 and zero in bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse, once per second |
| addr | input | 3 | Register address for reads and writes |
| wrData | input | 8 | Write data (only bit 6 at address 7 is used) |
| wrEn | input | 1 | Write strobe |
| rdData | output | 8 | Visible register selected by addr |

## Verification
The assertions assume that the start-time parameter holds legal, in-range BCD values, since the range checks on seconds and weekday rely on that. They also assume that secTick is a clean one-cycle pulse. The bench starts every instance from a legal date and time. It raises the tick for exactly one cycle with idle cycles between ticks. It drives the bus only at addresses 0 to 7, so the assumed input conditions always hold.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  localparam int REG_W     = 8;
  localparam int REG_COUNT = 8;
  localparam int ADDR_W    = $clog2(REG_COUNT);

  localparam int SEC_IDX  = 0;
  localparam int MIN_IDX  = 1;
  localparam int HOUR_IDX = 2;
  localparam int DOW_IDX  = 3;
  localparam int DATE_IDX = 4;
  localparam int MON_IDX  = 5;
  localparam int YEAR_IDX = 6;
  localparam int CENT_IDX = 7;
  localparam int HOLD_BIT = 6;

  // byte i is the value reloaded into register i when a field wraps
  localparam logic [REG_COUNT*REG_W-1:0] STEP_LOW = 64'h00_00_01_01_01_00_00_00;
  // default start: century 20, year 00, Jan 01, weekday 1, 00:00:00
  localparam logic [REG_COUNT*REG_W-1:0] DEFAULT_INIT = 64'h20_00_01_01_01_00_00_00;

  typedef struct packed {
    logic advance;  // counters step this cycle
    logic copyVis;  // visible bank loads from counters
  } calStrobe_t;

  function automatic logic [6:0] bcdToBin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] bcdStep(input logic [7:0] v, input logic [7:0] top,
                                         input logic [7:0] low);
    if (v == top)          return low;
    else if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                   return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] monthLast(input logic [7:0] mon, input logic [7:0] yr);
    logic [6:0] yrBin;
    yrBin = bcdToBin(yr);
    case (mon)
      8'h02:                      return (yrBin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_cal_ctrl.sv
module bcd_cal_ctrl
  import bcd_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output calStrobe_t        strobe,
  output logic              holdState
);

  logic centWrite;
  assign centWrite = wrEn && (addr == ADDR_W'(CENT_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n)         holdState <= 1'b0;
    else if (centWrite) holdState <= wrData[HOLD_BIT];
  end

  always_comb begin
    strobe.advance = secTick;
    strobe.copyVis = !holdState;
  end

  // R7: write to the century address loads the hold flag from bit 6
  p_hold_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    centWrite |=> (holdState == $past(wrData[HOLD_BIT])));

  // R9: no other access moves the hold flag
  p_hold_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !centWrite |=> $stable(holdState));

endmodule

// File: rtl/bcd_cal_datapath.sv
module bcd_cal_datapath
  import bcd_cal_pkg::*;
#(
  parameter logic [REG_COUNT*REG_W-1:0] INIT_TIME = DEFAULT_INIT
)(
  input  logic              clk,
  input  logic              rst_n,
  input  calStrobe_t        strobe,
  input  logic              holdState,
  input  logic [ADDR_W-1:0] addr,
  output logic [REG_W-1:0]  rdData
);

  logic [REG_W-1:0] cnt [REG_COUNT];
  logic [REG_W-1:0] vis [REG_COUNT];
  logic [REG_COUNT*REG_W-1:0] cntAll, visAll, stepTop;
  logic [REG_COUNT-1:0] stepEn;
  logic [REG_W-1:0] lastDate;
  logic secEnd, minEnd, dayEnd, monEnd, yrEnd, cenCarry;

  always_comb begin
    lastDate = monthLast(cnt[MON_IDX], cnt[YEAR_IDX]);
    secEnd   = (cnt[SEC_IDX] == 8'h59);
    minEnd   = secEnd && (cnt[MIN_IDX] == 8'h59);
    dayEnd   = minEnd && (cnt[HOUR_IDX] == 8'h23);
    monEnd   = dayEnd && (cnt[DATE_IDX] == lastDate);
    yrEnd    = monEnd && (cnt[MON_IDX] == 8'h12);
    cenCarry = yrEnd && (cnt[YEAR_IDX] == 8'h99);
    stepEn   = {cenCarry, yrEnd, monEnd, dayEnd, dayEnd, minEnd, secEnd, 1'b1};
    stepTop  = {8'h39, 8'h99, 8'h12, lastDate, 8'h07, 8'h23, 8'h59, 8'h59};
  end

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_field
    localparam logic [REG_W-1:0] INIT_I = (i == CENT_IDX) ?
      (INIT_TIME[REG_W*i +: REG_W] & 8'h3F) : INIT_TIME[REG_W*i +: REG_W];

    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt[i] <= INIT_I;
      else if (strobe.advance && stepEn[i])
        cnt[i] <= bcdStep(cnt[i], stepTop[REG_W*i +: REG_W], STEP_LOW[REG_W*i +: REG_W]);
    end

    always_ff @(posedge clk) begin
      if (!rst_n)              vis[i] <= INIT_I;
      else if (strobe.copyVis) vis[i] <= cnt[i];
    end

    assign cntAll[REG_W*i +: REG_W] = cnt[i];
    assign visAll[REG_W*i +: REG_W] = vis[i];
  end

  always_comb begin
    if (addr == ADDR_W'(CENT_IDX))
      rdData = {1'b0, holdState, vis[CENT_IDX][5:0]};
    else
      rdData = vis[addr];
  end

  // R7: visible bank is frozen while the hold flag is set
  p_vis_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.copyVis |=> $stable(visAll));

  // R8: an unfrozen cycle loads the whole bank from the counters together
  p_vis_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.copyVis |=> (visAll == $past(cntAll)));

  // R8: counters move on a tick regardless of the hold flag
  p_count_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance |=> !$stable(cnt[SEC_IDX]));

  // R2: seconds stay legal BCD in 00..59
  p_sec_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[SEC_IDX][3:0] <= 4'd9) && (cnt[SEC_IDX] <= 8'h59));

  // R4: weekday stays in 1..7 and moves only at the midnight rollover
  p_dow_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[DOW_IDX] >= 8'h01) && (cnt[DOW_IDX] <= 8'h07));

  p_dow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.advance && cnt[HOUR_IDX] == 8'h23 && cnt[MIN_IDX] == 8'h59
      && cnt[SEC_IDX] == 8'h59) |=> $stable(cnt[DOW_IDX]));

endmodule

// File: rtl/bcd_cal_clock.sv
module bcd_cal_clock
  import bcd_cal_pkg::*;
#(
  parameter logic [REG_COUNT*REG_W-1:0] INIT_TIME = DEFAULT_INIT
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              wrEn,
  output logic [REG_W-1:0]  rdData
);

  calStrobe_t strobe;
  logic       holdState;

  bcd_cal_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .secTick   (secTick),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrData    (wrData),
    .strobe    (strobe),
    .holdState (holdState)
  );

  bcd_cal_datapath #(.INIT_TIME(INIT_TIME)) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .holdState (holdState),
    .addr      (addr),
    .rdData    (rdData)
  );

endmodule

// File: tb/bcd_cal_clock_tb.sv
module bcd_cal_clock_tb;

  localparam int NVEC = 10;
  // {start value, expected value one tick later}; each half is
  // century, year, month, date, weekday, hours, minutes, seconds
  localparam logic [127:0] VEC [NVEC] = '{
    {64'h20_23_02_28_03_23_59_59, 64'h20_23_03_01_04_00_00_00},
    {64'h20_24_02_28_07_23_59_59, 64'h20_24_02_29_01_00_00_00},
    {64'h20_24_02_29_05_23_59_59, 64'h20_24_03_01_06_00_00_00},
    {64'h20_25_04_30_02_23_59_59, 64'h20_25_05_01_03_00_00_00},
    {64'h20_99_12_31_06_23_59_59, 64'h21_00_01_01_07_00_00_00},
    {64'h20_30_01_31_01_23_59_59, 64'h20_30_02_01_02_00_00_00},
    {64'h20_07_06_15_04_12_34_56, 64'h20_07_06_15_04_12_34_57},
    {64'h20_07_06_15_04_09_59_59, 64'h20_07_06_15_04_10_00_00},
    {64'h20_10_02_28_02_23_59_59, 64'h20_10_03_01_03_00_00_00},
    {64'h39_99_12_31_07_23_59_59, 64'h00_00_01_01_01_00_00_00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       secTick = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic       wrEn = 1'b0;
  logic [7:0] rdData;
  logic [7:0] vecRd [NVEC];

  int errors = 0;
  int checks = 0;
  int ticks = 0;

  always #4 clk = ~clk;

  bcd_cal_clock u_dut (
    .clk(clk), .rst_n(rst_n), .secTick(secTick), .addr(addr),
    .wrData(wrData), .wrEn(wrEn), .rdData(rdData)
  );

  for (genvar g = 0; g < NVEC; g++) begin : g_vec
    bcd_cal_clock #(.INIT_TIME(VEC[g][127:64])) u_vec (
      .clk(clk), .rst_n(rst_n), .secTick(secTick), .addr(addr),
      .wrData(8'h00), .wrEn(1'b0), .rdData(vecRd[g])
    );
  end

  function automatic logic [7:0] toBcd(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic string reqFor(input int idx);
    case (idx)
      0, 1, 2: return "R3";
      3:       return "R4";
      4:       return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    addr = 3'(a);
    #1;
    v = rdData;
  endtask

  task automatic doTick();
    @(negedge clk) secTick = 1'b1;
    @(negedge clk) secTick = 1'b0;
    ticks++;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic busWrite(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = 3'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk) wrEn = 1'b0;
  endtask

  task automatic checkTime(input string req);
    logic [7:0] v;
    rd(0, v); check(req, v, toBcd(ticks % 60));
    rd(1, v); check(req, v, toBcd((ticks / 60) % 60));
    rd(2, v); check(req, v, toBcd((ticks / 3600) % 24));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 address map
    rd(0, v); check("R1", v, 8'h00);
    rd(1, v); check("R1", v, 8'h00);
    rd(2, v); check("R1", v, 8'h00);
    rd(3, v); check("R1", v, 8'h01);
    rd(4, v); check("R1", v, 8'h01);
    rd(5, v); check("R1", v, 8'h01);
    rd(6, v); check("R1", v, 8'h00);
    rd(7, v); check("R1", v, 8'h20);
    addr = 3'd4; #1; check("R2", vecRd[0], 8'h28);

    // vector table: one tick per instance, all eight registers checked
    doTick();
    settle();
    for (int g = 0; g < NVEC; g++) begin
      for (int r = 0; r < 8; r++) begin
        addr = 3'(r);
        #1;
        check(reqFor(r), vecRd[g], VEC[g][8*r +: 8]);
      end
    end

    // R3 minute and hour carries on the default instance
    while (ticks < 60) doTick();
    settle();
    checkTime("R3");
    while (ticks < 3600) doTick();
    settle();
    checkTime("R3");

    // R7 hold freezes the visible bank; R10 hold visible in bit 6
    busWrite(7, 8'h40);
    repeat (5) doTick();
    settle();
    rd(0, v); check("R7", v, 8'h00);
    rd(2, v); check("R7", v, 8'h01);
    rd(7, v); check("R10", v, 8'h60);

    // R8 release: all registers show the ticks counted during the hold
    busWrite(7, 8'h00);
    @(negedge clk);
    checkTime("R8");
    rd(7, v); check("R10", v, 8'h20);

    // R9 writes do not alter time or century
    busWrite(0, 8'h45);
    settle();
    rd(0, v); check("R9", v, toBcd(ticks % 60));
    busWrite(3, 8'hFF);
    settle();
    rd(7, v); check("R9", v, 8'h20);
    busWrite(7, 8'hBF);
    settle();
    rd(7, v); check("R9", v, 8'h20);
    doTick();
    settle();
    checkTime("R9");
    busWrite(7, 8'hFF);
    settle();
    rd(7, v); check("R10", v, 8'h60);
    busWrite(7, 8'h00);
    settle();
    checkTime("R8");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule